// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver

This block recovers frames from a serial line that uses flag-delimited, bit-stuffed framing. The line is sampled one bit per clock in which `bit_en` is high. The block hunts for the delimiter `01111110` and removes the 0 that the sender places after every five consecutive 1s. It packs the remaining bits into characters whose length is set by a configuration input. The last sixteen bits before the closing delimiter form the frame check field. They are held back from the data output and are only used to check the frame.

At each closing delimiter the block checks a CRC-CCITT register for a fixed residue. It then reports the outcome on `frame_end`, together with `frame_ok`, `crc_err` and the number of bits left in an unfinished final character. A run of seven 1s inside a frame aborts that frame. The same run seen directly after a delimiter, outside any frame, is reported as an end-of-poll signal. An optional address filter drops every frame whose first character differs from a programmed value.

Top module: `hdlc_rx`

## Requirements
- R1: A frame consists of the data bits between two delimiters `01111110`, and one delimiter may both close one frame and open the next. Consecutive delimiters with no bits between them produce no output at all.
- R2: A 0 received directly after five consecutive 1s is discarded. It does not enter the character, the CRC or any bit count.
- R3: Characters are `5 + char_len_sel` bits long. The first bit received lands in bit 0 of `rx_data`, and the bits above the character length read as 0. Each delivered character gives a one-cycle pulse on `rx_valid`.
- R4: The final 16 data bits before a closing delimiter are never delivered as characters.
- R5: The CRC register uses polynomial 0x1021 and starts at 0xFFFF for every frame. It processes each data bit, check field included, in arrival order. At a closing delimiter `crc_err` is 1 exactly when the register differs from 0x1D0F.
- R6: `frame_ok` is 1 only when the CRC matches and at least one whole character was delivered. A frame made of only the check field therefore ends with `frame_ok` = 0.
- R7: With `frame_end`, `residue_bits` gives the number of data bits, not counting the check field, that are left over after the last whole character. The value is (data bits) mod (character length).
- R8: A seventh consecutive 1 inside a frame ends that frame. `frame_end` pulses with `abort_flag` = 1, `frame_ok` = 0 and `crc_err` = 0, and the receiver then hunts for the next delimiter.
- R9: A 0 followed by seven 1s, received directly after a delimiter and outside a frame, pulses `eop_flag` without any `frame_end`. Idle 1s after reset never pulse it.
- R10: When `addr_match_en` is 1, a frame whose first character is not equal to `match_addr` produces no `rx_valid`, `frame_start` or `frame_end`.
- R11: `frame_start` pulses in the same cycle as the first delivered character of an accepted frame.
- R12: After reset all output strobes are 0, and no output appears before the first delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `rx_bit` for this clock |
| rx_bit | input | 1 | Serial line bit |
| char_len_sel | input | 2 | Character length minus 5 |
| addr_match_en | input | 1 | Enables address filtering |
| match_addr | input | 8 | Address the first character must equal |
| rx_data | output | 8 | Received character, right-justified |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| frame_start | output | 1 | First character of an accepted frame |
| frame_end | output | 1 | Frame closed or aborted |
| frame_ok | output | 1 | Frame valid, qualified by `frame_end` |
| crc_err | output | 1 | Check field mismatch, qualified by `frame_end` |
| abort_flag | output | 1 | Frame aborted, qualified by `frame_end` |
| eop_flag | output | 1 | End-of-poll pulse |
| residue_bits | output | 3 | Bits in the final partial character |

## Verification
The bench builds the block with its default parameters: 8-bit characters, a minimum length of 5 and a 16-bit check field. This lets `char_len_sel` reach all four character lengths, so residues from 0 to 7 can occur. Random frames mix all four lengths, bit counts from zero to sixty, payloads rich in 1s that force zero stuffing, and bit-enable gaps of zero to two idle clocks. Directed frames cover the one-character boundary, frames with only the check field, a corrupted check field, abort, end-of-poll, a shared delimiter, and matching and non-matching addresses.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int DELIM_W  = 8;
  localparam int FCS_W    = 16;
  localparam logic [FCS_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [FCS_W-1:0] CRC_INIT = 16'hFFFF;
  localparam logic [FCS_W-1:0] CRC_GOOD = 16'h1D0F;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_OPEN,
    ST_BODY
  } frm_state_t;
endpackage

// File: rtl/hdlc_rx_line.sv
// Delimiter/abort detection and zero deletion. Bits leave through an
// 8-bit window so a delimiter is recognised before any of its bits
// could be delivered as data; events trail the last data bit by a clock.
module hdlc_rx_line
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  output logic dv,
  output logic db,
  output logic flag_ev,
  output logic seven_ev
);
  localparam int RUN_W = 3;

  logic [DELIM_W-1:0] win;
  logic [DELIM_W-1:0] kill;
  logic [RUN_W-1:0]   ones;
  logic               pend_flag, pend_seven;
  logic               is_stuff, is_flag, is_seven, is_idle;

  always_comb begin
    is_stuff = !rx_bit && (ones == RUN_W'(5));
    is_flag  = !rx_bit && (ones == RUN_W'(6));
    is_seven =  rx_bit && (ones == RUN_W'(6));
    is_idle  =  rx_bit && (ones == RUN_W'(7));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win        <= '0;
      kill       <= '1;
      ones       <= '0;
      dv         <= 1'b0;
      db         <= 1'b0;
      pend_flag  <= 1'b0;
      pend_seven <= 1'b0;
      flag_ev    <= 1'b0;
      seven_ev   <= 1'b0;
    end else begin
      dv         <= 1'b0;
      pend_flag  <= 1'b0;
      pend_seven <= 1'b0;
      flag_ev    <= pend_flag;
      seven_ev   <= pend_seven;
      if (bit_en) begin
        dv  <= !kill[DELIM_W-1];
        db  <= win[DELIM_W-1];
        win <= {win[DELIM_W-2:0], rx_bit};
        if (is_flag || is_seven)
          kill <= '1;
        else
          kill <= {kill[DELIM_W-2:0], is_stuff || is_idle};
        if (!rx_bit)
          ones <= '0;
        else if (ones != RUN_W'(7))
          ones <= ones + RUN_W'(1);
        pend_flag  <= is_flag;
        pend_seven <= is_seven;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         d,
  output logic [W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      crc <= INIT;
    else if (en)
      crc <= {crc[W-2:0], 1'b0} ^ ((crc[W-1] ^ d) ? POLY : '0);
  end
endmodule

// File: rtl/hdlc_rx_asm.sv
// Holds back the check field and packs the bits in front of it into
// characters, first bit at position 0.
module hdlc_rx_asm #(
  parameter int CHAR_W   = 8,
  parameter int MIN_CHAR = 5,
  parameter int SEL_W    = 2,
  parameter int HOLD     = 16,
  localparam int CNT_W   = $clog2(CHAR_W),
  localparam int HC_W    = $clog2(HOLD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              d,
  input  logic [SEL_W-1:0]  len_sel,
  output logic              o_valid,
  output logic              o_first,
  output logic              o_have,
  output logic [CHAR_W-1:0] o_char,
  output logic [CNT_W-1:0]  o_pos
);
  logic [HOLD-1:0]   hold;
  logic [HC_W-1:0]   hcnt;
  logic [CHAR_W-1:0] acc, acc_nxt, mask;
  logic [CNT_W-1:0]  last;

  assign last = CNT_W'(MIN_CHAR - 1) + CNT_W'(len_sel);

  generate
    for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
      assign mask[i] = (CNT_W'(i) <= last);
    end
  endgenerate

  always_comb begin
    acc_nxt        = acc;
    acc_nxt[o_pos] = hold[HOLD-1];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hold    <= '0;
      hcnt    <= '0;
      acc     <= '0;
      o_pos   <= '0;
      o_valid <= 1'b0;
      o_first <= 1'b0;
      o_have  <= 1'b0;
      if (rst) o_char <= '0;
    end else begin
      o_valid <= 1'b0;
      if (en) begin
        hold <= {hold[HOLD-2:0], d};
        if (hcnt != HC_W'(HOLD)) begin
          hcnt <= hcnt + HC_W'(1);
        end else begin
          acc <= acc_nxt;
          if (o_pos == last) begin
            o_pos   <= '0;
            o_valid <= 1'b1;
            o_char  <= acc_nxt & mask;
            o_first <= !o_have;
            o_have  <= 1'b1;
          end else begin
            o_pos <= o_pos + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int MIN_CHAR = 5,
  parameter int SEL_W    = 2,
  localparam int CNT_W   = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic [SEL_W-1:0]  char_len_sel,
  input  logic              addr_match_en,
  input  logic [CHAR_W-1:0] match_addr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_start,
  output logic              frame_end,
  output logic              frame_ok,
  output logic              crc_err,
  output logic              abort_flag,
  output logic              eop_flag,
  output logic [CNT_W-1:0]  residue_bits
);
  logic              dv, db, flag_ev, seven_ev;
  logic              feed, clr;
  logic [FCS_W-1:0]  crc;
  logic              a_valid, a_first, a_have;
  logic [CHAR_W-1:0] a_char;
  logic [CNT_W-1:0]  a_pos;
  frm_state_t        st;
  logic              rej, rej_now, addr_hit;

  assign feed = dv && (st != ST_HUNT);
  assign clr  = flag_ev || seven_ev;

  hdlc_rx_line i_line (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .dv(dv), .db(db), .flag_ev(flag_ev), .seven_ev(seven_ev)
  );

  hdlc_rx_crc #(.W(FCS_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc (
    .clk(clk), .rst(rst), .clr(clr), .en(feed), .d(db), .crc(crc)
  );

  hdlc_rx_asm #(.CHAR_W(CHAR_W), .MIN_CHAR(MIN_CHAR), .SEL_W(SEL_W), .HOLD(FCS_W)) i_asm (
    .clk(clk), .rst(rst), .clr(clr), .en(feed), .d(db), .len_sel(char_len_sel),
    .o_valid(a_valid), .o_first(a_first), .o_have(a_have),
    .o_char(a_char), .o_pos(a_pos)
  );

  assign addr_hit = !addr_match_en || (a_char == match_addr);
  assign rej_now  = rej || (a_valid && a_first && !addr_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_HUNT;
      rej          <= 1'b0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      frame_start  <= 1'b0;
      frame_end    <= 1'b0;
      frame_ok     <= 1'b0;
      crc_err      <= 1'b0;
      abort_flag   <= 1'b0;
      eop_flag     <= 1'b0;
      residue_bits <= '0;
    end else begin
      rx_valid    <= a_valid && !rej_now;
      frame_start <= a_valid && a_first && !rej_now;
      if (a_valid) rx_data <= a_char;
      frame_end <= 1'b0;
      eop_flag  <= 1'b0;
      rej       <= rej_now;
      if (flag_ev) begin
        if (st == ST_BODY && !rej_now) begin
          frame_end    <= 1'b1;
          crc_err      <= (crc != CRC_GOOD);
          frame_ok     <= (crc == CRC_GOOD) && a_have;
          abort_flag   <= 1'b0;
          residue_bits <= a_pos;
        end
        st  <= ST_OPEN;
        rej <= 1'b0;
      end else if (seven_ev) begin
        if (st == ST_BODY && !rej_now) begin
          frame_end    <= 1'b1;
          crc_err      <= 1'b0;
          frame_ok     <= 1'b0;
          abort_flag   <= 1'b1;
          residue_bits <= a_pos;
        end else if (st == ST_OPEN) begin
          eop_flag <= 1'b1;
        end
        st  <= ST_HUNT;
        rej <= 1'b0;
      end else if (dv && st == ST_OPEN) begin
        st <= ST_BODY;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk #(
  parameter int CHAR_W   = 8,
  parameter int MIN_CHAR = 5,
  parameter int SEL_W    = 2,
  localparam int CNT_W   = $clog2(CHAR_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  char_len_sel,
  input logic [CHAR_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              frame_start,
  input logic              frame_end,
  input logic              frame_ok,
  input logic              crc_err,
  input logic              abort_flag,
  input logic              eop_flag,
  input logic [CNT_W-1:0]  residue_bits
);
  a_r11_start_has_char: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> rx_valid);

  a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> (MIN_CHAR + int'(char_len_sel))) == '0));

  a_r8_abort_is_bad: assert property (@(posedge clk) disable iff (rst)
    (frame_end && abort_flag) |-> (!frame_ok && !crc_err));

  a_r6_ok_needs_crc: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !(frame_ok && crc_err));

  a_r9_eop_outside_frame: assert property (@(posedge clk) disable iff (rst)
    eop_flag |-> !frame_end);

  a_r7_residue_short: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (int'(residue_bits) < MIN_CHAR + int'(char_len_sel)));
endmodule

bind hdlc_rx hdlc_rx_chk #(.CHAR_W(CHAR_W), .MIN_CHAR(MIN_CHAR), .SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_hdlc_rx.sv
module test_hdlc_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       rx_bit = 1'b1;
  logic [1:0] char_len_sel = 2'd3;
  logic       addr_match_en = 1'b0;
  logic [7:0] match_addr = 8'h00;
  logic [7:0] rx_data;
  logic       rx_valid, frame_start, frame_end, frame_ok, crc_err, abort_flag, eop_flag;
  logic [2:0] residue_bits;

  always #4 clk = ~clk;

  hdlc_rx i_hdlc_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .char_len_sel(char_len_sel), .addr_match_en(addr_match_en), .match_addr(match_addr),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_start(frame_start),
    .frame_end(frame_end), .frame_ok(frame_ok), .crc_err(crc_err),
    .abort_flag(abort_flag), .eop_flag(eop_flag), .residue_bits(residue_bits)
  );

  int n_cmp = 0, n_bad = 0, gap = 0;
  int n_end = 0, n_start = 0, n_eop = 0;
  logic e_ok, e_crc, e_abort;
  logic [2:0] e_res;
  int got_q[$];
  bit pl_q[$];
  int exp_q[$];
  bit done = 0;

  always @(negedge clk) if (!rst) begin
    if (rx_valid) got_q.push_back(int'(rx_data));
    if (frame_start) n_start++;
    if (eop_flag) n_eop++;
    if (frame_end) begin
      n_end++; e_ok = frame_ok; e_crc = crc_err; e_abort = abort_flag; e_res = residue_bits;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic send_raw(input bit b);
    rx_bit = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_flag();
    send_raw(0);
    for (int i = 0; i < 6; i++) send_raw(1);
    send_raw(0);
  endtask

  task automatic clear_mon();
    got_q.delete(); n_end = 0; n_start = 0; n_eop = 0;
    e_ok = 0; e_crc = 0; e_abort = 0; e_res = 0;
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input bit d);
    return {c[14:0], 1'b0} ^ ((c[15] ^ d) ? 16'h1021 : 16'h0000);
  endfunction

  // Send pl_q plus its check field, with zero stuffing (R2, R5).
  task automatic send_body(input bit corrupt);
    logic [15:0] c = 16'hFFFF;
    bit tx[$];
    int run = 0;
    foreach (pl_q[i]) begin c = crc_step(c, pl_q[i]); tx.push_back(pl_q[i]); end
    c = ~c;
    if (corrupt) c[0] = ~c[0];
    for (int i = 15; i >= 0; i--) tx.push_back(c[i]);
    foreach (tx[i]) begin
      send_raw(tx[i]);
      if (tx[i]) begin
        run++;
        if (run == 5) begin send_raw(0); run = 0; end
      end else run = 0;
    end
  endtask

  task automatic idle_wait();
    repeat (6) @(negedge clk);
  endtask

  task automatic run_frame(input int nbits, input int sel, input bit corrupt, input int bias, input string tag);
    int len = 5 + sel;
    int nch = nbits / len;
    bit rejected = 0;
    char_len_sel = 2'(sel);
    pl_q.delete(); exp_q.delete();
    for (int i = 0; i < nbits; i++) pl_q.push_back(($urandom % 8) < bias);
    for (int k = 0; k < nch; k++) begin
      int ch = 0;
      for (int j = 0; j < len; j++) ch |= int'(pl_q[k*len + j]) << j;
      exp_q.push_back(ch);
    end
    if (addr_match_en && nch > 0 && exp_q[0] != int'(match_addr)) rejected = 1;
    clear_mon();
    send_flag();
    send_body(corrupt);
    send_flag();
    idle_wait();
    if (rejected) begin
      check(n_end == 0, "R10", {tag, " frame_end count"}, n_end, 0);
      check(got_q.size() == 0, "R10", {tag, " delivered chars"}, got_q.size(), 0);
      check(n_start == 0, "R10", {tag, " frame_start count"}, n_start, 0);
    end else begin
      check(got_q.size() == nch, "R4", {tag, " char count"}, got_q.size(), nch);
      for (int k = 0; k < nch && k < got_q.size(); k++)
        check(got_q[k] == exp_q[k], "R3", {tag, " char value"}, got_q[k], exp_q[k]);
      check(n_start == (nch > 0 ? 1 : 0), "R11", {tag, " frame_start count"}, n_start, nch > 0 ? 1 : 0);
      check(n_end == 1, "R1", {tag, " frame_end count"}, n_end, 1);
      check(e_crc == corrupt, "R5", {tag, " crc_err"}, int'(e_crc), int'(corrupt));
      check(e_ok == (!corrupt && nch > 0), "R6", {tag, " frame_ok"}, int'(e_ok), int'(!corrupt && nch > 0));
      check(int'(e_res) == nbits % len, "R7", {tag, " residue"}, int'(e_res), nbits % len);
      check(e_abort == 0, "R8", {tag, " abort_flag"}, int'(e_abort), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: quiet after reset, idle ones give nothing
    check(!rx_valid && !frame_end && !eop_flag && !frame_start, "R12", "strobes after reset",
          int'(rx_valid | frame_end | eop_flag | frame_start), 0);
    clear_mon();
    for (int i = 0; i < 20; i++) send_raw(1);
    idle_wait();
    check(n_eop == 0, "R9", "eop from idle ones", n_eop, 0);
    check(n_end == 0 && got_q.size() == 0, "R12", "output before delimiter", n_end, 0);

    // R1: only delimiters
    clear_mon();
    send_flag(); send_flag(); send_flag();
    idle_wait();
    check(n_end == 0 && n_start == 0, "R1", "delimiters alone", n_end + n_start, 0);

    // Directed boundaries
    run_frame(0, 3, 0, 4, "check-field only");     // R6
    run_frame(8, 3, 0, 4, "one char");             // R6 boundary
    run_frame(7, 3, 0, 4, "seven bits");           // R6, R7
    run_frame(13, 0, 0, 4, "len5 residue3");       // R7
    run_frame(24, 3, 0, 8, "all ones");            // R2
    run_frame(32, 2, 1, 4, "bad check field");     // R5

    // R8: abort inside a frame
    clear_mon();
    send_flag();
    for (int i = 0; i < 12; i++) send_raw(i % 2 == 0);
    for (int i = 0; i < 8; i++) send_raw(1);
    send_flag();
    idle_wait();
    check(n_end == 1, "R8", "abort frame_end count", n_end, 1);
    check(e_abort == 1 && e_ok == 0 && e_crc == 0, "R8", "abort status", int'(e_abort), 1);
    check(got_q.size() == 0, "R8", "abort delivered chars", got_q.size(), 0);

    // R9: end-of-poll right after a delimiter
    clear_mon();
    send_flag();
    send_raw(0);
    for (int i = 0; i < 8; i++) send_raw(1);
    send_flag();
    idle_wait();
    check(n_eop == 1, "R9", "eop count", n_eop, 1);
    check(n_end == 0, "R9", "frame_end with eop", n_end, 0);

    // R1: shared delimiter between two frames
    clear_mon();
    char_len_sel = 2'd3;
    send_flag();
    pl_q.delete(); for (int i = 0; i < 16; i++) pl_q.push_back(i % 3 == 0);
    send_body(0);
    send_flag();
    pl_q.delete(); for (int i = 0; i < 24; i++) pl_q.push_back(i % 5 == 1);
    send_body(0);
    send_flag();
    idle_wait();
    check(n_end == 2, "R1", "shared delimiter frame_end count", n_end, 2);
    check(got_q.size() == 5, "R1", "shared delimiter char count", got_q.size(), 5);

    // R10: address filter
    addr_match_en = 1'b1;
    match_addr = 8'h00;
    run_frame(24, 3, 0, 0, "addr match");
    match_addr = 8'h5A;
    run_frame(24, 3, 0, 0, "addr mismatch");
    addr_match_en = 1'b0;

    // Random frames
    for (int f = 0; f < 40; f++) begin
      gap = $urandom % 3;
      run_frame($urandom % 61, $urandom % 4, ($urandom % 5) == 0, 4 + ($urandom % 4), "random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule